// File: doc/BRIEF.md
# Buffered Up/Down PWM Timebase

This block is the timebase of one pulse-width modulation channel. A counter steps once per cycle while the timer is running and a clock-enable input is high. The counter runs in one of three shapes. In edge alignment it is a sawtooth from zero up to the period. In center alignment it is a triangle that climbs to the period and falls back to zero. Asymmetric alignment uses the same triangle, but the rising and falling halves use different compare values.

The period and each of the two compare channels have an active value and a buffered value. At a terminal count, a pair exchanges its two values when its own exchange enable is set, or when a swap request has been latched since the last terminal count. This lets software stage new values without tearing a running cycle. Start, reload and swap strobes each pass through an edge or level detector that is selected per input. Compare-match events can be enabled separately for each channel and each count direction. Two trigger outputs each carry one internal event chosen by a select code.

Software writes the six value registers through a plain write port: address 0 active period, 1 buffered period, 2 active compare 0, 3 buffered compare 0, 4 active compare 1, 5 buffered compare 1. The mode settings are static input ports.

Top module: `pwm_updown_timer`

## Requirements
- R1: After reset the count is 0, the direction is up, the timer is stopped, and pwmOut, tcOut, ovfOut, unfOut, both match strobes and both triggers are low.
- R2: Each strobe input is turned into an event according to its mode code: 0 rising edge, 1 falling edge, 2 either edge, 3 every cycle the input is high. A start event makes the timer run from its present count without changing it. Counting begins on the cycle after the event.
- R3: A reload event sets the count to 0 and the direction to up, and makes the timer run. It takes precedence over a count step in the same cycle, and that cycle raises no event strobe.
- R4: The count changes only when a step occurs, and a step occurs only on a cycle where the timer is running and cntEn is high.
- R5: Alignment code 0 (edge) counts 0,1,…,P and then returns to 0. The step from P to 0 raises ovfOut and tcOut for one cycle, together with the new count. unfOut stays low.
- R6: Alignment code 1 (center, and also code 3) counts up to P and then down to 0. The step leaving P raises ovfOut and sets dirDown. The step leaving 0 while counting down raises unfOut and tcOut and clears dirDown. ovfOut and unfOut are never high together.
- R7: Alignment code 2 (asymmetric) counts as in R6, but tcOut rises on both ovfOut and unfOut steps. While dirDown is low, pwmOut is high when the count is below compare 0. While dirDown is high, pwmOut is high when the count is below compare 1.
- R8: In edge and center alignment, with the flip option off, pwmOut is high exactly when the count is below the active compare 0 value.
- R9: In center or asymmetric alignment with flipOnUfOv high, pwmOut goes high with each unfOut and goes low with each ovfOut. In edge alignment the option has no effect.
- R10: cmp0Match or cmp1Match is high for the one cycle after a step whose new count equals that channel's active compare value. In edge alignment a match always counts. Otherwise cmpMatchEn gates it: bit 0 enables channel 0 counting up, bit 1 channel 0 counting down, bit 2 channel 1 counting up, bit 3 channel 1 counting down. The direction used is dirDown after the step.
- R11: At a terminal count, the period pair, compare 0 pair and compare 1 pair each exchange their active and buffered values when periodSwapEn, cmp0SwapEn or cmp1SwapEn respectively is high. The new values apply from the next step.
- R12: A swap event latches a request. At the next terminal count that follows the event's cycle, all three pairs exchange once and the request clears. An event that arrives in the same cycle as a terminal count waits for the following terminal count.
- R13: Each trigger output follows the event chosen by its 3-bit select: 0 none, 1 ovfOut, 2 unfOut, 3 tcOut, 4 cmp0Match, 5 cmp1Match, 6 and 7 none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cntEn | input | 1 | Count enable; a running timer steps once per cycle while this is high |
| startIn | input | 1 | Start strobe |
| reloadIn | input | 1 | Reload strobe |
| swapIn | input | 1 | Swap request strobe |
| startMode | input | 2 | Detector mode for startIn |
| reloadMode | input | 2 | Detector mode for reloadIn |
| swapMode | input | 2 | Detector mode for swapIn |
| alignMode | input | 2 | 0 edge, 1 center, 2 asymmetric, 3 center |
| flipOnUfOv | input | 1 | Output set on underflow, cleared on overflow (non-edge modes) |
| periodSwapEn | input | 1 | Exchange period pair at terminal count |
| cmp0SwapEn | input | 1 | Exchange compare 0 pair at terminal count |
| cmp1SwapEn | input | 1 | Exchange compare 1 pair at terminal count |
| cmpMatchEn | input | 4 | Per-channel, per-direction match enables |
| trig0Sel | input | 3 | Event select for trig0 |
| trig1Sel | input | 3 | Event select for trig1 |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 3 | Register write address |
| cfgWrData | input | CNT_W | Register write data |
| count | output | CNT_W | Current counter value |
| dirDown | output | 1 | High while counting down |
| pwmOut | output | 1 | Raw PWM level |
| tcOut | output | 1 | Terminal-count strobe |
| ovfOut | output | 1 | Overflow strobe (step leaving the period) |
| unfOut | output | 1 | Underflow strobe (step leaving zero downward) |
| cmp0Match | output | 1 | Compare 0 match strobe |
| cmp1Match | output | 1 | Compare 1 match strobe |
| trig0 | output | 1 | Selected event 0 |
| trig1 | output | 1 | Selected event 1 |

## Verification
The assertions check the following on every cycle:
- The count moves only on a step or a reload.
- A reload lands on zero counting up.
- Overflow and underflow are mutually exclusive and agree with the direction flag.
- An edge-mode wrap lands on zero with a terminal count.
- A center terminal count is always an underflow.
- The active period takes the old buffered value when an enabled exchange coincides with a terminal count.
- The flip output follows the underflow and overflow strobes.

Only the bench's scenarios show the rest:
- The exact count sequences and match timing across periods, compare values and enable patterns.
- The detector modes.
- When a latched swap request takes effect.
- The trigger routing.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  localparam logic [1:0] ALIGN_EDGE   = 2'd0;
  localparam logic [1:0] ALIGN_CENTER = 2'd1;
  localparam logic [1:0] ALIGN_ASYM   = 2'd2;

  localparam logic [1:0] IN_RISE  = 2'd0;
  localparam logic [1:0] IN_FALL  = 2'd1;
  localparam logic [1:0] IN_BOTH  = 2'd2;
  localparam logic [1:0] IN_LEVEL = 2'd3;

  localparam int NUM_STROBE_IN = 3;
  localparam int NUM_PAIRS     = 3;

  // control -> datapath
  typedef struct packed {
    logic step;
    logic reload;
    logic swapReq;
  } ctrlStrobes_t;

  // datapath -> trigger routing
  typedef struct packed {
    logic ovf;
    logic unf;
    logic tc;
    logic match0;
    logic match1;
  } timerEvents_t;

  function automatic logic detectEvent(logic [1:0] mode, logic cur, logic prev);
    case (mode)
      IN_RISE: return cur & ~prev;
      IN_FALL: return ~cur & prev;
      IN_BOTH: return cur ^ prev;
      default: return cur;
    endcase
  endfunction

  function automatic logic pickEvent(logic [2:0] sel, timerEvents_t ev);
    case (sel)
      3'd1:    return ev.ovf;
      3'd2:    return ev.unf;
      3'd3:    return ev.tc;
      3'd4:    return ev.match0;
      3'd5:    return ev.match1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pwm_timer_ctrl.sv
module pwm_timer_ctrl
  import pwm_timer_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cntEn,
  input  logic         startIn,
  input  logic         reloadIn,
  input  logic         swapIn,
  input  logic [1:0]   startMode,
  input  logic [1:0]   reloadMode,
  input  logic [1:0]   swapMode,
  input  logic         tcNext,
  output ctrlStrobes_t stb
);

  logic [NUM_STROBE_IN-1:0]      rawIn;
  logic [NUM_STROBE_IN-1:0]      prevIn;
  logic [NUM_STROBE_IN-1:0]      evHit;
  logic [NUM_STROBE_IN-1:0][1:0] modeArr;
  logic                          running;
  logic                          swapPend;

  assign rawIn   = {swapIn, reloadIn, startIn};
  assign modeArr = {swapMode, reloadMode, startMode};

  for (genvar gi = 0; gi < NUM_STROBE_IN; gi++) begin : g_detect
    assign evHit[gi] = detectEvent(modeArr[gi], rawIn[gi], prevIn[gi]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevIn   <= '0;
      running  <= 1'b0;
      swapPend <= 1'b0;
    end else begin
      prevIn <= rawIn;
      if (evHit[0] || evHit[1]) running <= 1'b1;
      swapPend <= evHit[2] | (swapPend & ~tcNext);
    end
  end

  always_comb begin
    stb.reload  = evHit[1];
    stb.step    = running & cntEn & ~evHit[1];
    stb.swapReq = swapPend;
  end

endmodule

// File: rtl/pwm_timer_datapath.sv
module pwm_timer_datapath
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctrlStrobes_t       stb,
  input  logic [1:0]         alignMode,
  input  logic               flipOnUfOv,
  input  logic               periodSwapEn,
  input  logic               cmp0SwapEn,
  input  logic               cmp1SwapEn,
  input  logic [3:0]         cmpMatchEn,
  input  logic               cfgWrEn,
  input  logic [2:0]         cfgAddr,
  input  logic [CNT_W-1:0]   cfgWrData,
  output logic [CNT_W-1:0]   count,
  output logic               dirDown,
  output logic               pwmOut,
  output timerEvents_t       ev,
  output logic               tcNext,
  output logic [CNT_W-1:0]   periodAct,
  output logic [CNT_W-1:0]   periodBuf
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [NUM_PAIRS-1:0][CNT_W-1:0] actV;
  logic [NUM_PAIRS-1:0][CNT_W-1:0] bufV;
  logic [NUM_PAIRS-1:0]            swapEnV;

  logic [CNT_W-1:0] cntQ, cntN;
  logic             dirQ, dirN;
  logic             ovfQ, unfQ, tcQ, stepQ, flipQ;
  logic             ovfN, unfN, tcN;
  logic             isEdge, isAsym;

  assign swapEnV = {cmp1SwapEn, cmp0SwapEn, periodSwapEn};
  assign isEdge  = (alignMode == ALIGN_EDGE);
  assign isAsym  = (alignMode == ALIGN_ASYM);

  // active/buffered register pairs: 0 period, 1 compare 0, 2 compare 1
  for (genvar gp = 0; gp < NUM_PAIRS; gp++) begin : g_pair
    logic [CNT_W-1:0] actQ, bufQ;
    logic             wrAct, wrBuf, doSwap;

    assign wrAct  = cfgWrEn && (cfgAddr == 3'(2 * gp));
    assign wrBuf  = cfgWrEn && (cfgAddr == 3'(2 * gp + 1));
    assign doSwap = tcNext && (swapEnV[gp] || stb.swapReq);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        actQ <= '0;
        bufQ <= '0;
      end else begin
        if (wrAct)       actQ <= cfgWrData;
        else if (doSwap) actQ <= bufQ;
        if (wrBuf)       bufQ <= cfgWrData;
        else if (doSwap) bufQ <= actQ;
      end
    end

    assign actV[gp] = actQ;
    assign bufV[gp] = bufQ;
  end

  // next-state of the counter
  always_comb begin
    cntN = cntQ;
    dirN = dirQ;
    ovfN = 1'b0;
    unfN = 1'b0;
    tcN  = 1'b0;
    if (stb.reload) begin
      cntN = '0;
      dirN = 1'b0;
    end else if (stb.step) begin
      if (isEdge) begin
        dirN = 1'b0;
        if (cntQ >= actV[0]) begin
          cntN = '0;
          ovfN = 1'b1;
          tcN  = 1'b1;
        end else begin
          cntN = cntQ + ONE;
        end
      end else if (!dirQ) begin
        if (cntQ >= actV[0]) begin
          dirN = 1'b1;
          cntN = (cntQ == '0) ? '0 : cntQ - ONE;
          ovfN = 1'b1;
          tcN  = isAsym;
        end else begin
          cntN = cntQ + ONE;
        end
      end else begin
        if (cntQ == '0) begin
          dirN = 1'b0;
          cntN = (actV[0] == '0) ? '0 : ONE;
          unfN = 1'b1;
          tcN  = 1'b1;
        end else begin
          cntN = cntQ - ONE;
        end
      end
    end
  end

  assign tcNext = tcN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntQ  <= '0;
      dirQ  <= 1'b0;
      ovfQ  <= 1'b0;
      unfQ  <= 1'b0;
      tcQ   <= 1'b0;
      stepQ <= 1'b0;
      flipQ <= 1'b0;
    end else begin
      cntQ  <= cntN;
      dirQ  <= dirN;
      ovfQ  <= ovfN;
      unfQ  <= unfN;
      tcQ   <= tcN;
      stepQ <= stb.step;
      if (unfN)      flipQ <= 1'b1;
      else if (ovfN) flipQ <= 1'b0;
    end
  end

  // compare matches evaluated on the count a step produced
  logic en0, en1;
  assign en0 = isEdge | (dirQ ? cmpMatchEn[1] : cmpMatchEn[0]);
  assign en1 = isEdge | (dirQ ? cmpMatchEn[3] : cmpMatchEn[2]);

  always_comb begin
    ev.ovf    = ovfQ;
    ev.unf    = unfQ;
    ev.tc     = tcQ;
    ev.match0 = stepQ && (cntQ == actV[1]) && en0;
    ev.match1 = stepQ && (cntQ == actV[2]) && en1;
  end

  always_comb begin
    if (isEdge)                pwmOut = cntQ < actV[1];
    else if (flipOnUfOv)       pwmOut = flipQ;
    else if (isAsym && dirQ)   pwmOut = cntQ < actV[2];
    else                       pwmOut = cntQ < actV[1];
  end

  assign count     = cntQ;
  assign dirDown   = dirQ;
  assign periodAct = actV[0];
  assign periodBuf = bufV[0];

endmodule

// File: rtl/pwm_updown_timer.sv
module pwm_updown_timer
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cntEn,
  input  logic             startIn,
  input  logic             reloadIn,
  input  logic             swapIn,
  input  logic [1:0]       startMode,
  input  logic [1:0]       reloadMode,
  input  logic [1:0]       swapMode,
  input  logic [1:0]       alignMode,
  input  logic             flipOnUfOv,
  input  logic             periodSwapEn,
  input  logic             cmp0SwapEn,
  input  logic             cmp1SwapEn,
  input  logic [3:0]       cmpMatchEn,
  input  logic [2:0]       trig0Sel,
  input  logic [2:0]       trig1Sel,
  input  logic             cfgWrEn,
  input  logic [2:0]       cfgAddr,
  input  logic [CNT_W-1:0] cfgWrData,
  output logic [CNT_W-1:0] count,
  output logic             dirDown,
  output logic             pwmOut,
  output logic             tcOut,
  output logic             ovfOut,
  output logic             unfOut,
  output logic             cmp0Match,
  output logic             cmp1Match,
  output logic             trig0,
  output logic             trig1
);

  ctrlStrobes_t     stb;
  timerEvents_t     ev;
  logic             tcNext;
  logic [CNT_W-1:0] periodAct;
  logic [CNT_W-1:0] periodBuf;

  pwm_timer_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cntEn      (cntEn),
    .startIn    (startIn),
    .reloadIn   (reloadIn),
    .swapIn     (swapIn),
    .startMode  (startMode),
    .reloadMode (reloadMode),
    .swapMode   (swapMode),
    .tcNext     (tcNext),
    .stb        (stb)
  );

  pwm_timer_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .stb          (stb),
    .alignMode    (alignMode),
    .flipOnUfOv   (flipOnUfOv),
    .periodSwapEn (periodSwapEn),
    .cmp0SwapEn   (cmp0SwapEn),
    .cmp1SwapEn   (cmp1SwapEn),
    .cmpMatchEn   (cmpMatchEn),
    .cfgWrEn      (cfgWrEn),
    .cfgAddr      (cfgAddr),
    .cfgWrData    (cfgWrData),
    .count        (count),
    .dirDown      (dirDown),
    .pwmOut       (pwmOut),
    .ev           (ev),
    .tcNext       (tcNext),
    .periodAct    (periodAct),
    .periodBuf    (periodBuf)
  );

  assign tcOut     = ev.tc;
  assign ovfOut    = ev.ovf;
  assign unfOut    = ev.unf;
  assign cmp0Match = ev.match0;
  assign cmp1Match = ev.match1;
  assign trig0     = pickEvent(trig0Sel, ev);
  assign trig1     = pickEvent(trig1Sel, ev);

endmodule

// File: rtl/pwm_timer_checker.sv
module pwm_timer_checker
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       alignMode,
  input logic             flipOnUfOv,
  input logic             periodSwapEn,
  input logic             cfgWrEn,
  input ctrlStrobes_t     stb,
  input logic [CNT_W-1:0] count,
  input logic             dirDown,
  input logic             pwmOut,
  input logic             tcOut,
  input logic             ovfOut,
  input logic             unfOut,
  input logic [CNT_W-1:0] periodAct,
  input logic [CNT_W-1:0] periodBuf
);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.step && !stb.reload) |=> ($stable(count) && $stable(dirDown)));

  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stb.reload |=> (count == '0 && !dirDown && !tcOut && !ovfOut && !unfOut));

  p_edge_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (alignMode == ALIGN_EDGE && ovfOut) |-> (count == '0 && tcOut));

  p_ovf_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (alignMode != ALIGN_EDGE && ovfOut) |-> dirDown);

  p_unf_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    unfOut |-> !dirDown);

  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovfOut, unfOut}));

  p_center_tc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (alignMode == ALIGN_CENTER && tcOut) |-> unfOut);

  p_period_swap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tcOut && $past(periodSwapEn) && !$past(cfgWrEn)) |-> (periodAct == $past(periodBuf)));

  p_flip_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flipOnUfOv && alignMode != ALIGN_EDGE && unfOut) |-> pwmOut);

  p_flip_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flipOnUfOv && alignMode != ALIGN_EDGE && ovfOut) |-> !pwmOut);

endmodule

bind pwm_updown_timer pwm_timer_checker #(.CNT_W(CNT_W)) u_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .alignMode    (alignMode),
  .flipOnUfOv   (flipOnUfOv),
  .periodSwapEn (periodSwapEn),
  .cfgWrEn      (cfgWrEn),
  .stb          (stb),
  .count        (count),
  .dirDown      (dirDown),
  .pwmOut       (pwmOut),
  .tcOut        (tcOut),
  .ovfOut       (ovfOut),
  .unfOut       (unfOut),
  .periodAct    (periodAct),
  .periodBuf    (periodBuf)
);

// File: tb/tb_pwm_updown_timer.sv
`timescale 1ns/1ps
module tb_pwm_updown_timer;
  localparam int W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n;
  logic         cntEn, startIn, reloadIn, swapIn;
  logic [1:0]   startMode, reloadMode, swapMode, alignMode;
  logic         flipOnUfOv, periodSwapEn, cmp0SwapEn, cmp1SwapEn;
  logic [3:0]   cmpMatchEn;
  logic [2:0]   trig0Sel, trig1Sel;
  logic         cfgWrEn;
  logic [2:0]   cfgAddr;
  logic [W-1:0] cfgWrData;
  logic [W-1:0] count;
  logic         dirDown, pwmOut, tcOut, ovfOut, unfOut, cmp0Match, cmp1Match, trig0, trig1;

  pwm_updown_timer #(.CNT_W(W)) dut (.*);

  int nChecks = 0;
  int nFail   = 0;

  task automatic chk(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic idle();
    cntEn = 1'b0; startIn = 1'b0; reloadIn = 1'b0; swapIn = 1'b0;
    cyc(); cyc();
  endtask

  task automatic wr(int addr, int data);
    cfgWrEn = 1'b1; cfgAddr = 3'(addr); cfgWrData = W'(data);
    cyc();
    cfgWrEn = 1'b0;
  endtask

  task automatic doReload();
    reloadIn = 1'b1;
    cyc();
    reloadIn = 1'b0;
  endtask

  function automatic int pick(int sel, int o, int u, int t, int m0, int m1);
    case (sel)
      1: return o;
      2: return u;
      3: return t;
      4: return m0;
      5: return m1;
      default: return 0;
    endcase
  endfunction

  // arithmetic expectation for edge / center / asymmetric runs without swaps
  task automatic runCheck(int al, int P, int c0, int c1, int en, int flip, int nsteps, int s0, int s1);
    int cnt, dir, o, u, t, m0, m1, pw, M, m, flipValid, flipLvl;
    string rc, rp;
    idle();
    alignMode = 2'(al); flipOnUfOv = flip[0]; cmpMatchEn = 4'(en);
    periodSwapEn = 0; cmp0SwapEn = 0; cmp1SwapEn = 0;
    trig0Sel = 3'(s0); trig1Sel = 3'(s1); reloadMode = 2'd0;
    wr(0, P); wr(1, P); wr(2, c0); wr(3, c0); wr(4, c1); wr(5, c1);
    doReload();
    chk("R3", "count after reload", int'(count), 0);
    chk("R3", "dir after reload", int'(dirDown), 0);
    cntEn = 1'b1;
    flipValid = 0; flipLvl = 0;
    rc = (al == 0) ? "R5" : "R6";
    for (int k = 1; k <= nsteps; k++) begin
      cyc();
      if (al == 0) begin
        m = k % (P + 1);
        cnt = m; dir = 0; o = (m == 0); u = 0; t = o;
        m0 = (cnt == c0); m1 = (cnt == c1);
        pw = (cnt < c0); rp = "R8";
      end else begin
        M = 2 * P; m = k % M;
        cnt = (m <= P) ? m : M - m;
        dir = (m > P) || (m == 0);
        o = ((k - 1) % M == P);
        u = ((k - 1) % M == 0) && (k > 1);
        t = (al == 2) ? (o | u) : u;
        m0 = (cnt == c0) && (dir ? en[1] : en[0]);
        m1 = (cnt == c1) && (dir ? en[3] : en[2]);
        if (u) begin flipLvl = 1; flipValid = 1; end
        if (o) begin flipLvl = 0; flipValid = 1; end
        if (flip != 0) begin pw = flipLvl; rp = "R9"; end
        else if (al == 2) begin pw = dir ? (cnt < c1) : (cnt < c0); rp = "R7"; end
        else begin pw = (cnt < c0); rp = "R8"; end
      end
      chk(rc, "count", int'(count), cnt);
      chk(rc, "dirDown", int'(dirDown), dir);
      chk(rc, "ovfOut", int'(ovfOut), o);
      chk(rc, "unfOut", int'(unfOut), u);
      chk((al == 2) ? "R7" : rc, "tcOut", int'(tcOut), t);
      chk("R10", "cmp0Match", int'(cmp0Match), m0);
      chk("R10", "cmp1Match", int'(cmp1Match), m1);
      if (al == 0 || flip == 0 || flipValid != 0) chk(rp, "pwmOut", int'(pwmOut), pw);
      chk("R13", "trig0", int'(trig0), pick(s0, o, u, t, m0, m1));
      chk("R13", "trig1", int'(trig1), pick(s1, o, u, t, m0, m1));
    end
  endtask

  // edge-mode run with buffered pairs: P 3/5, cmp0 1/3, cmp1 2/4
  task automatic swapRun(int pEn, int c0En, int c1En, int pulseAt, int nsteps);
    int act[3], bf[3], en[3], cnt, tc, pend, tmp;
    string r;
    r = (pulseAt > 0) ? "R12" : "R11";
    idle();
    alignMode = 2'd0; flipOnUfOv = 0; cmpMatchEn = 4'd0; swapMode = 2'd0;
    periodSwapEn = pEn[0]; cmp0SwapEn = c0En[0]; cmp1SwapEn = c1En[0];
    trig0Sel = 3'd3; trig1Sel = 3'd5;
    wr(0, 3); wr(1, 5); wr(2, 1); wr(3, 3); wr(4, 2); wr(5, 4);
    act = '{3, 1, 2}; bf = '{5, 3, 4}; en = '{pEn, c0En, c1En};
    doReload();
    cntEn = 1'b1; cnt = 0; pend = 0;
    for (int k = 1; k <= nsteps; k++) begin
      swapIn = (k == pulseAt);
      cyc();
      tc = (cnt >= act[0]);
      cnt = tc ? 0 : cnt + 1;
      for (int p = 0; p < 3; p++)
        if (tc != 0 && (en[p] != 0 || pend != 0)) begin
          tmp = act[p]; act[p] = bf[p]; bf[p] = tmp;
        end
      pend = (k == pulseAt) ? 1 : (pend & (tc == 0 ? 1 : 0));
      chk(r, "count", int'(count), cnt);
      chk(r, "tcOut", int'(tcOut), tc);
      chk(r, "pwmOut vs compare 0", int'(pwmOut), (cnt < act[1]) ? 1 : 0);
      chk(r, "cmp1Match", int'(cmp1Match), (cnt == act[2]) ? 1 : 0);
    end
    swapIn = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    cntEn = 0; startIn = 0; reloadIn = 0; swapIn = 0;
    startMode = 0; reloadMode = 0; swapMode = 0; alignMode = 0;
    flipOnUfOv = 0; periodSwapEn = 0; cmp0SwapEn = 0; cmp1SwapEn = 0;
    cmpMatchEn = 0; trig0Sel = 3'd3; trig1Sel = 3'd1;
    cfgWrEn = 0; cfgAddr = 0; cfgWrData = 0;
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    chk("R1", "count", int'(count), 0);
    chk("R1", "dirDown", int'(dirDown), 0);
    chk("R1", "pwmOut", int'(pwmOut), 0);
    chk("R1", "tcOut", int'(tcOut), 0);
    chk("R1", "ovf/unf", int'({ovfOut, unfOut}), 0);
    chk("R1", "matches", int'({cmp0Match, cmp1Match}), 0);
    chk("R1", "triggers", int'({trig0, trig1}), 0);
    // R1: stopped after reset, cntEn alone does not count
    wr(0, 9); wr(1, 9);
    cntEn = 1'b1;
    cyc(); cyc();
    chk("R1", "stopped after reset", int'(count), 0);
    // R2 falling-edge start
    startMode = 2'd1; startIn = 1'b1;
    cyc(); cyc();
    chk("R2", "no start while high", int'(count), 0);
    startIn = 1'b0;
    cyc();
    chk("R2", "start cycle", int'(count), 0);
    cyc();
    chk("R2", "first step", int'(count), 1);
    cyc();
    chk("R2", "second step", int'(count), 2);
    // R2 rising start while running keeps count
    startMode = 2'd0; startIn = 1'b1;
    cyc();
    chk("R2", "start keeps count", int'(count), 3);
    startIn = 1'b0;
    // R4 gating
    cntEn = 1'b0;
    cyc(); cyc();
    chk("R4", "held with cntEn low", int'(count), 3);
    cntEn = 1'b1;
    cyc();
    chk("R4", "resumes", int'(count), 4);
    cntEn = 1'b0; cyc(); cntEn = 1'b1; cyc();
    chk("R4", "one gap", int'(count), 5);
    // R2/R3 level-mode reload
    reloadMode = 2'd3; reloadIn = 1'b1;
    cyc(); chk("R3", "level reload 1", int'(count), 0);
    cyc(); chk("R2", "level reload 2", int'(count), 0);
    cyc(); chk("R2", "level reload 3", int'(count), 0);
    reloadIn = 1'b0;
    cyc(); chk("R2", "after level release", int'(count), 1);
    // R2 both-edge reload
    reloadMode = 2'd2;
    cyc(); cyc(); chk("R2", "both mode idle", int'(count), 3);
    reloadIn = 1'b1;
    cyc(); chk("R2", "both rise", int'(count), 0);
    cyc(); chk("R2", "both high", int'(count), 1);
    reloadIn = 1'b0;
    cyc(); chk("R2", "both fall", int'(count), 0);
    cyc(); chk("R2", "both after", int'(count), 1);
    reloadMode = 2'd0;

    // edge sweeps (R5, R8, R10 edge, R13)
    for (int P = 1; P <= 5; P++)
      for (int c0 = 0; c0 <= P + 1; c0++)
        runCheck(0, P, c0, P - c0 < 0 ? 0 : P - c0, 0, 0, 2 * (P + 1) + 2, c0 % 8, (c0 + 3) % 8);
    // center sweeps over match enables (R6, R8, R10, R13)
    for (int P = 1; P <= 4; P++)
      for (int c0 = 0; c0 <= P + 1; c0++)
        for (int en = 0; en < 16; en++)
          runCheck(1, P, c0, (c0 + 1) % (P + 1), en, 0, 4 * P + 1, en % 8, (en + 5) % 8);
    // asymmetric sweeps (R7)
    for (int P = 1; P <= 4; P++)
      for (int c0 = 0; c0 <= P + 1; c0++)
        for (int c1 = 0; c1 <= P + 1; c1++)
          runCheck(2, P, c0, c1, 15, 0, 4 * P + 1, 3, 2);
    // flip option (R9), including edge where it is ignored
    runCheck(1, 3, 2, 1, 15, 1, 20, 1, 2);
    runCheck(2, 4, 1, 3, 15, 1, 24, 3, 4);
    runCheck(0, 4, 2, 1, 0, 1, 12, 1, 3);
    // alignment code 3 acts as center
    runCheck(3, 3, 2, 1, 5, 0, 14, 2, 4);
    // buffered exchange (R11) and swap requests (R12)
    swapRun(1, 1, 1, 0, 16);
    swapRun(1, 0, 0, 0, 16);
    swapRun(0, 0, 0, 2, 20);
    swapRun(0, 0, 0, 4, 20);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule